// File: doc/BRIEF.md
# Radix-Adjusted Nibble Add-With-Carry Unit

This execution unit runs the two add-with-carry instructions of a 4-bit processor whose sum is reduced to a radix chosen by the opcode. The radix can be anything from 1 to 16. The memory-destination form adds the B register and the carry into a data-memory nibble. The register-destination form adds a data-memory nibble and the carry into B, then advances the index register that addressed the memory.

The unit does not hold the B, X and Y registers or the flags. It samples them when it accepts an instruction and returns write strobes with the new values. The data memory has a synchronous read. The address and read strobe go out in the accept cycle, and the read data comes back in the following cycle. The unit writes its result in that second cycle and raises a completion strobe.

An extension prefix can be loaded just before an instruction. It replaces the index register as the memory address of the next memory-destination instruction.

Top module: `radix_adc_unit`

## Requirements
- R1: The unit accepts an instruction only when it is idle, `start_i` is high and `instr_i[15:4]` is 0x1D4, 0x1D6, 0x1DD or 0x1DF. Instruction bit 7 selects the register-destination form and bit 5 selects Y over X. Any other opcode raises no read, write or done, and it leaves a pending prefix in place.
- R2: The radix is 16 minus `instr_i[3:0]`, so code 0 means 16 and code 0xF means 1. The unit forms sum = memory nibble + B + carry-in. If sum is at least the radix, the result is sum minus the radix (low 4 bits) and the carry is 1. Otherwise the result is sum and the carry is 0.
- R3: In the memory-destination forms, the result is written to the read address in the second cycle, and B is not written.
- R4: In the register-destination forms, the result is written to B. Only the index register that was used is written, with its sampled value plus one, wrapping from 0xFFFF to 0x0000.
- R5: In the second cycle the flags are written as follows: E is 0, C is as in R2, and Z is 1 exactly when the result is zero. The index increment has no influence on any flag. The I flag has no output and is never touched.
- R6: The read strobe and read address are driven in the accept cycle, and `done_o` and `busy_o` are high in the next cycle only. A start during that busy cycle is ignored.
- R7: After a prefix load (`ext_set_i` with `ext_imm_i`), the next memory-destination instruction uses address 0x0000+imm with X, or 0xFF00+imm with Y, for both its read and its write.
- R8: The register-destination forms always address through the index register, even with a prefix pending. Any accepted instruction clears the pending prefix.
- R9: After reset no strobe is active, the unit is idle and no prefix is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Instruction present |
| instr_i | input | 16 | Instruction word |
| b_i | input | 4 | Current B register |
| c_i | input | 1 | Current carry flag |
| x_i | input | 16 | Current X index register |
| y_i | input | 16 | Current Y index register |
| ext_set_i | input | 1 | Load extension prefix |
| ext_imm_i | input | 8 | Prefix immediate |
| mem_re_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 16 | Memory address (read and write) |
| mem_rdata_i | input | 4 | Read data, valid the cycle after the read |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 4 | Memory write data |
| b_we_o | output | 1 | B register write enable |
| b_o | output | 4 | New B value |
| x_we_o | output | 1 | X register write enable |
| y_we_o | output | 1 | Y register write enable |
| idx_o | output | 16 | New index value |
| flag_we_o | output | 1 | E, C and Z flag write enable |
| e_o | output | 1 | New E flag |
| c_o | output | 1 | New C flag |
| z_o | output | 1 | New Z flag |
| busy_o | output | 1 | Second cycle in progress |
| done_o | output | 1 | Instruction completes this cycle |

## Verification
In the register-destination form, the index post-increment and the flag update happen in the same completion cycle. The bench provokes this by running a post-increment with X at 0xFFFF, so the index wraps to zero while the nibble result is non-zero. It passes only if Z stays 0 and C follows the radix sum, with `idx_o` at 0x0000. A second case runs a zero result beside a non-zero index, and the bench checks that Z follows the result alone. The bench also exercises a start held high through the busy cycle.

// File: rtl/radix_adc_pkg.sv
package radix_adc_pkg;
  typedef enum logic {
    KIND_MEM_DST = 1'b0,
    KIND_REG_INC = 1'b1
  } adc_kind_e;

  typedef struct packed {
    logic      legal;
    adc_kind_e kind;
    logic      use_y;
    logic [3:0] code;
  } adc_dec_t;
endpackage

// File: rtl/radix_adc_decode.sv
module radix_adc_decode
  import radix_adc_pkg::*;
(
  input  logic [15:0] instr_i,
  output adc_dec_t    dec_o
);
  always_comb begin
    dec_o       = '0;
    dec_o.code  = instr_i[3:0];
    dec_o.use_y = instr_i[5];
    dec_o.kind  = instr_i[7] ? KIND_REG_INC : KIND_MEM_DST;
    case (instr_i[15:4])
      12'h1D4, 12'h1D6, 12'h1DD, 12'h1DF: dec_o.legal = 1'b1;
      default:                            dec_o.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/radix_adc_alu.sv
module radix_adc_alu #(
  parameter int NIB_W = 4
) (
  input  logic [NIB_W-1:0] a_i,
  input  logic [NIB_W-1:0] b_i,
  input  logic             cin_i,
  input  logic [NIB_W-1:0] code_i,
  output logic [NIB_W-1:0] res_o,
  output logic             carry_o
);
  localparam int SUM_W = NIB_W + 2;

  logic [SUM_W-1:0] radix, sum, diff;

  always_comb begin
    // radix = 2**NIB_W - code, code 0 selects the full binary radix
    radix   = {2'b01, {NIB_W{1'b0}}} - {2'b00, code_i};
    sum     = {2'b00, a_i} + {2'b00, b_i} + {{(SUM_W-1){1'b0}}, cin_i};
    diff    = sum - radix;
    carry_o = (sum >= radix);
    res_o   = carry_o ? diff[NIB_W-1:0] : sum[NIB_W-1:0];
  end
endmodule

// File: rtl/radix_adc_ctrl.sv
module radix_adc_ctrl
  import radix_adc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NIB_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  adc_dec_t          dec_i,
  input  logic [NIB_W-1:0]  b_i,
  input  logic              c_i,
  input  logic [ADDR_W-1:0] x_i,
  input  logic [ADDR_W-1:0] y_i,
  input  logic              ext_set_i,
  input  logic [ADDR_W/2-1:0] ext_imm_i,
  output logic              accept_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] idx_next_o,
  output adc_kind_e         kind_o,
  output logic              use_y_o,
  output logic [NIB_W-1:0]  code_o,
  output logic [NIB_W-1:0]  b_o,
  output logic              c_o
);
  localparam int IMM_W = ADDR_W / 2;
  localparam int HI_W  = ADDR_W - IMM_W;

  logic              busy_q, ext_pend_q;
  logic [IMM_W-1:0]  ext_imm_q;
  logic [ADDR_W-1:0] addr_q, idx_sel, ext_addr, rd_addr;

  assign accept_o = !busy_q && start_i && dec_i.legal;
  assign idx_sel  = dec_i.use_y ? y_i : x_i;
  assign ext_addr = {{HI_W{dec_i.use_y}}, ext_imm_q};
  assign rd_addr  = (ext_pend_q && dec_i.kind == KIND_MEM_DST) ? ext_addr : idx_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      ext_pend_q <= 1'b0;
      ext_imm_q  <= '0;
      addr_q     <= '0;
      kind_o     <= KIND_MEM_DST;
      use_y_o    <= 1'b0;
      code_o     <= '0;
      b_o        <= '0;
      c_o        <= 1'b0;
    end else begin
      busy_q <= accept_o;
      if (ext_set_i) begin
        ext_pend_q <= 1'b1;
        ext_imm_q  <= ext_imm_i;
      end else if (accept_o) begin
        ext_pend_q <= 1'b0;
      end
      if (accept_o) begin
        addr_q  <= rd_addr;
        kind_o  <= dec_i.kind;
        use_y_o <= dec_i.use_y;
        code_o  <= dec_i.code[NIB_W-1:0];
        b_o     <= b_i;
        c_o     <= c_i;
      end
    end
  end

  assign busy_o     = busy_q;
  assign addr_o     = busy_q ? addr_q : rd_addr;
  assign idx_next_o = addr_q + {{(ADDR_W-1){1'b0}}, 1'b1};
endmodule

// File: rtl/radix_adc_unit.sv
module radix_adc_unit
  import radix_adc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [15:0]       instr_i,
  input  logic [3:0]        b_i,
  input  logic              c_i,
  input  logic [ADDR_W-1:0] x_i,
  input  logic [ADDR_W-1:0] y_i,
  input  logic              ext_set_i,
  input  logic [ADDR_W/2-1:0] ext_imm_i,
  output logic              mem_re_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [3:0]        mem_rdata_i,
  output logic              mem_we_o,
  output logic [3:0]        mem_wdata_o,
  output logic              b_we_o,
  output logic [3:0]        b_o,
  output logic              x_we_o,
  output logic              y_we_o,
  output logic [ADDR_W-1:0] idx_o,
  output logic              flag_we_o,
  output logic              e_o,
  output logic              c_o,
  output logic              z_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int NIB_W = 4;

  adc_dec_t         dec;
  adc_kind_e        kind_q;
  logic             use_y_q, c_q, accept, busy, carry;
  logic [NIB_W-1:0] code_q, b_q, res;

  radix_adc_decode u_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  radix_adc_ctrl #(.ADDR_W(ADDR_W), .NIB_W(NIB_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .dec_i      (dec),
    .b_i        (b_i),
    .c_i        (c_i),
    .x_i        (x_i),
    .y_i        (y_i),
    .ext_set_i  (ext_set_i),
    .ext_imm_i  (ext_imm_i),
    .accept_o   (accept),
    .busy_o     (busy),
    .addr_o     (mem_addr_o),
    .idx_next_o (idx_o),
    .kind_o     (kind_q),
    .use_y_o    (use_y_q),
    .code_o     (code_q),
    .b_o        (b_q),
    .c_o        (c_q)
  );

  radix_adc_alu #(.NIB_W(NIB_W)) u_alu (
    .a_i     (mem_rdata_i),
    .b_i     (b_q),
    .cin_i   (c_q),
    .code_i  (code_q),
    .res_o   (res),
    .carry_o (carry)
  );

  assign mem_re_o    = accept;
  assign mem_we_o    = busy && kind_q == KIND_MEM_DST;
  assign mem_wdata_o = res;
  assign b_we_o      = busy && kind_q == KIND_REG_INC;
  assign b_o         = res;
  assign x_we_o      = b_we_o && !use_y_q;
  assign y_we_o      = b_we_o && use_y_q;
  assign flag_we_o   = busy;
  assign e_o         = 1'b0;
  assign c_o         = carry;
  assign z_o         = (res == '0);
  assign busy_o      = busy;
  assign done_o      = busy;
endmodule

// File: rtl/radix_adc_unit_chk.sv
module radix_adc_unit_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_re_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_we_o,
  input logic [3:0]        mem_wdata_o,
  input logic              b_we_o,
  input logic [3:0]        b_o,
  input logic              x_we_o,
  input logic              y_we_o,
  input logic [ADDR_W-1:0] idx_o,
  input logic [ADDR_W-1:0] x_i,
  input logic [ADDR_W-1:0] y_i,
  input logic              flag_we_o,
  input logic              e_o,
  input logic              z_o,
  input logic              busy_o,
  input logic              done_o
);
  // R6
  re_then_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> done_o);
  // R6
  done_after_re_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mem_re_o));
  // R6
  busy_no_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !mem_re_o);
  // R3
  one_dest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (mem_we_o ^ b_we_o));
  // R4
  x_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    x_we_o |-> (!y_we_o && idx_o == ADDR_W'($past(x_i) + 1)));
  // R4
  y_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_we_o |-> (!x_we_o && idx_o == ADDR_W'($past(y_i) + 1)));
  // R5
  flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_o |-> (!e_o && z_o == ((b_we_o ? b_o : mem_wdata_o) == 4'h0)));
  // R7
  wr_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_addr_o == $past(mem_addr_o));
endmodule

bind radix_adc_unit radix_adc_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_re_o    (mem_re_o),
  .mem_addr_o  (mem_addr_o),
  .mem_we_o    (mem_we_o),
  .mem_wdata_o (mem_wdata_o),
  .b_we_o      (b_we_o),
  .b_o         (b_o),
  .x_we_o      (x_we_o),
  .y_we_o      (y_we_o),
  .idx_o       (idx_o),
  .x_i         (x_i),
  .y_i         (y_i),
  .flag_we_o   (flag_we_o),
  .e_o         (e_o),
  .z_o         (z_o),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/radix_adc_unit_test.sv
`timescale 1ns/1ps
module radix_adc_unit_test;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        start_i = 1'b0, c_i = 1'b0, ext_set_i = 1'b0;
  logic [15:0] instr_i = '0, x_i = '0, y_i = '0;
  logic [3:0]  b_i = '0, mem_rdata_i = '0;
  logic [7:0]  ext_imm_i = '0;
  logic        mem_re_o, mem_we_o, b_we_o, x_we_o, y_we_o, flag_we_o;
  logic        e_o, c_o, z_o, busy_o, done_o;
  logic [15:0] mem_addr_o, idx_o;
  logic [3:0]  mem_wdata_o, b_o;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  radix_adc_unit uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] ref_adc(input logic [3:0] a, b, input logic c, input logic [3:0] code);
    int r = 16 - int'(code);
    int s = int'(a) + int'(b) + int'(c);
    if (s >= r) return {1'b1, 4'(s - r)};
    return {1'b0, 4'(s)};
  endfunction

  task automatic load_prefix(input logic [7:0] v);
    @(negedge clk_i); ext_set_i = 1'b1; ext_imm_i = v;
    @(negedge clk_i); ext_set_i = 1'b0;
  endtask

  task automatic run_op(input logic [15:0] ins, input logic [3:0] b, input logic c,
                        input logic [15:0] x, y, input logic [3:0] rd, input logic [15:0] exp_addr);
    logic [4:0] e = ref_adc(rd, b, c, ins[3:0]);
    bit inc = ins[7], uy = ins[5];
    @(negedge clk_i);
    start_i = 1'b1; instr_i = ins; b_i = b; c_i = c; x_i = x; y_i = y; #1;
    chk(mem_re_o == 1'b1, "R6 read strobe", int'(mem_re_o), 1);
    chk(mem_addr_o == exp_addr, "R7/R8 read addr", int'(mem_addr_o), int'(exp_addr));
    @(negedge clk_i);
    start_i = 1'b0; mem_rdata_i = rd; b_i = ~b; c_i = ~c; #1;
    chk(done_o && busy_o && !mem_re_o, "R6 done", int'(done_o), 1);
    chk(flag_we_o && c_o == e[4], "R2 carry", int'(c_o), int'(e[4]));
    chk(z_o == (e[3:0] == 4'h0) && e_o == 1'b0, "R5 flags", int'({e_o, z_o}), int'(e[3:0] == 4'h0));
    if (!inc) begin
      chk(mem_we_o && !b_we_o && !x_we_o && !y_we_o, "R3 mem dest", int'({mem_we_o, b_we_o}), 2);
      chk(mem_wdata_o == e[3:0], "R2 mem result", int'(mem_wdata_o), int'(e[3:0]));
      chk(mem_addr_o == exp_addr, "R3 write addr", int'(mem_addr_o), int'(exp_addr));
    end else begin
      chk(b_we_o && !mem_we_o, "R4 reg dest", int'({mem_we_o, b_we_o}), 1);
      chk(b_o == e[3:0], "R2 reg result", int'(b_o), int'(e[3:0]));
      chk(x_we_o == !uy && y_we_o == uy, "R4 index select", int'({x_we_o, y_we_o}), uy ? 1 : 2);
      chk(idx_o == 16'(exp_addr + 16'd1), "R4 index inc", int'(idx_o), int'(16'(exp_addr + 16'd1)));
    end
    @(negedge clk_i); #1;
    chk(!done_o && !mem_we_o && !b_we_o && !flag_we_o, "R6 single done", int'(done_o), 0);
  endtask

  task automatic t_reset();
    #1;
    chk(!done_o && !busy_o && !mem_re_o && !mem_we_o && !b_we_o && !flag_we_o && !x_we_o && !y_we_o,
        "R9 reset idle", int'(done_o), 0);
  endtask

  task automatic t_mem_dst();
    run_op(16'h1D46, 4'd5, 1'b1, 16'h1234, 16'h8000, 4'd7, 16'h1234); // R3 radix 10 carry
    run_op(16'h1D60, 4'd6, 1'b1, 16'h1111, 16'hABCD, 4'd9, 16'hABCD); // R2 radix 16 to zero
    run_op(16'h1D47, 4'd2, 1'b0, 16'h0042, 16'h0, 4'd3, 16'h0042);    // R2 radix 9 below
  endtask

  task automatic t_post_inc();
    run_op(16'h1DD6, 4'd3, 1'b0, 16'hFFFF, 16'h0001, 4'd4, 16'hFFFF); // R4 R5 wrap, Z from result
    run_op(16'h1DFF, 4'd0, 1'b0, 16'h0, 16'h00FF, 4'd0, 16'h00FF);    // R2 radix 1, sum 0
    run_op(16'h1DFF, 4'd0, 1'b1, 16'h0, 16'h0FFF, 4'd0, 16'h0FFF);    // R2 radix 1, carry
    run_op(16'h1DD0, 4'hF, 1'b1, 16'h7FFF, 16'h0, 4'hF, 16'h7FFF);    // R2 radix 16 max
  endtask

  task automatic t_prefix();
    load_prefix(8'h5A);
    run_op(16'h1D46, 4'd1, 1'b0, 16'h3333, 16'h4444, 4'd2, 16'h005A); // R7 X page
    load_prefix(8'hC3);
    run_op(16'h1D63, 4'd8, 1'b0, 16'h3333, 16'h4444, 4'd8, 16'hFFC3); // R7 Y page
    run_op(16'h1D40, 4'd1, 1'b0, 16'h3333, 16'h4444, 4'd1, 16'h3333); // R8 cleared
    load_prefix(8'h77);
    run_op(16'h1DF6, 4'd1, 1'b0, 16'h3333, 16'h4444, 4'd1, 16'h4444); // R8 post-inc ignores
    run_op(16'h1D60, 4'd1, 1'b0, 16'h3333, 16'h4444, 4'd1, 16'h4444); // R8 consumed by post-inc
  endtask

  task automatic t_illegal();
    load_prefix(8'h21);
    foreach (instr_i[i]) begin end
    for (int k = 0; k < 3; k++) begin
      logic [15:0] bad = (k == 0) ? 16'h1D50 : (k == 1) ? 16'h1DE0 : 16'h1C40;
      @(negedge clk_i); start_i = 1'b1; instr_i = bad; #1;
      chk(!mem_re_o, "R1 illegal no read", int'(mem_re_o), 0);
      @(negedge clk_i); start_i = 1'b0; #1;
      chk(!done_o && !mem_we_o && !b_we_o, "R1 illegal no done", int'(done_o), 0);
    end
    run_op(16'h1D40, 4'd2, 1'b0, 16'h0999, 16'h0, 4'd2, 16'h0021); // R1 prefix kept
  endtask

  task automatic t_busy_start();
    @(negedge clk_i);
    start_i = 1'b1; instr_i = 16'h1D46; b_i = 4'd1; c_i = 1'b0; x_i = 16'h0100; #1;
    chk(mem_re_o, "R6 accept", int'(mem_re_o), 1);
    @(negedge clk_i);
    instr_i = 16'h1DD0; x_i = 16'h0200; mem_rdata_i = 4'd1; #1;
    chk(!mem_re_o && done_o, "R6 start while busy ignored", int'(mem_re_o), 0);
    chk(mem_we_o && !b_we_o && mem_wdata_o == 4'd2, "R6 busy result kept", int'(mem_wdata_o), 2);
    start_i = 1'b0;
    @(negedge clk_i); #1;
    chk(!done_o && !b_we_o, "R6 no second op", int'(done_o), 0);
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  %0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_mem_dst();
    t_post_inc();
    t_prefix();
    t_illegal();
    t_busy_start();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule